// File: doc/BRIEF.md
# Reserved-Region Error Target Agent

This block sits on an interconnect as the target for an address window that has no memory or register behind it. Any request whose address falls inside the window is answered with an error response. The agent keeps a record of the first such error: which initiator issued it, and the arbitration pressure the request carried. Software can use this record to find out which master touched the window and at what priority. The block sees only the last hop of a request. When an access was forwarded by a proxy initiator, the record therefore shows the proxy's identifier and the proxy's pressure.

The record is sticky. Once it is filled, it stays frozen until software writes a word of all ones to the status register. Requests that arrive while the record is full still receive their error response, but they are not recorded. A small register port lets software read the status word and the detail word, and clear the record.

Top module: `tgt_err_logger`

## Requirements
- R1: A request with `req_valid` high whose address lies in the 16 MB window (bits 31:24 equal to those of `REGION_BASE`, default 0x45) produces `rsp_valid` and `rsp_err` both high in the next cycle.
- R2: A request outside the window produces no response in the next cycle (`rsp_valid` low) and leaves the record untouched.
- R3: While no error is recorded, the status register (offset 0x48) and the detail register (offset 0x4C) both read as zero, and so does the reset state.
- R4: After an error is recorded, the status register reads 0x00080001.
- R5: The detail register holds the recorded pressure in bits 7:6 and the recorded initiator identifier in bits 5:0, with all other bits zero. Both values are those presented on the request port, so a proxy's identifier and pressure are the ones recorded.
- R6: While a record is held, later in-window requests do not change the status or detail contents.
- R7: In-window requests are still answered with an error while the record is full.
- R8: Writing 0xFFFFFFFF to offset 0x48 clears the record, so that both registers read zero. The next in-window request is then recorded.
- R9: A write of any other value to offset 0x48, and a write to any other offset, has no effect on the record.
- R10: When a clearing write and an in-window request occur in the same cycle, the request is recorded.
- R11: Read data appears on `cfg_rdata` in the cycle after `cfg_rd_en`. Any offset other than 0x48 and 0x4C reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe from the interconnect |
| req_addr | input | 32 | Request address |
| req_init_id | input | 6 | Identifier of the presenting initiator |
| req_press | input | 2 | Arbitration pressure of the request |
| rsp_valid | output | 1 | Response strobe, one cycle after an in-window request |
| rsp_err | output | 1 | Error flag qualifying the response |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |

## Verification
Each response is due one clock edge after its request, and each read value is due one edge after its read strobe. The bench drives every stimulus at a falling edge and samples at the next falling edge, which lands just after the edge that registers the result. A record is read back on the cycle after the request that fills it, so the capture edge comes before the read edge. The same-cycle case drives the clearing write and the request in one cycle and then reads the detail word. This shows whether the new request won.

// File: rtl/tel_pkg.sv
package tel_pkg;
  localparam int unsigned CFG_AW      = 12;
  localparam int unsigned DATA_W      = 32;
  localparam logic [CFG_AW-1:0] OFS_STATUS = 12'h048;
  localparam logic [CFG_AW-1:0] OFS_DETAIL = 12'h04C;
  localparam logic [DATA_W-1:0] STATUS_CODE = 32'h0008_0001;
  localparam logic [DATA_W-1:0] CLEAR_WORD  = {DATA_W{1'b1}};
endpackage

// File: rtl/tel_region_dec.sv
module tel_region_dec #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SPAN_W      = 24,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4500_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              err_evt,
  output logic              rsp_valid,
  output logic              rsp_err
);
  localparam int unsigned TAG_W = ADDR_W - SPAN_W;

  logic in_win;

  generate
    if (TAG_W == 0) begin : g_all
      assign in_win = 1'b1;
    end else begin : g_tag
      assign in_win = (req_addr[ADDR_W-1:SPAN_W] == REGION_BASE[ADDR_W-1:SPAN_W]);
    end
  endgenerate

  assign err_evt = req_valid && in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= err_evt;
      rsp_err   <= err_evt;
    end
  end
endmodule

// File: rtl/tel_capture.sv
module tel_capture #(
  parameter int unsigned ID_W    = 6,
  parameter int unsigned PRESS_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               err_evt,
  input  logic [ID_W-1:0]    evt_id,
  input  logic [PRESS_W-1:0] evt_press,
  input  logic               clr,
  output logic               log_vld,
  output logic [ID_W-1:0]    log_id,
  output logic [PRESS_W-1:0] log_press
);
  logic take;
  assign take = err_evt && (!log_vld || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      log_vld   <= 1'b0;
      log_id    <= '0;
      log_press <= '0;
    end else if (take) begin
      log_vld   <= 1'b1;
      log_id    <= evt_id;
      log_press <= evt_press;
    end else if (clr) begin
      log_vld   <= 1'b0;
      log_id    <= '0;
      log_press <= '0;
    end
  end
endmodule

// File: rtl/tel_regs.sv
module tel_regs
  import tel_pkg::*;
#(
  parameter int unsigned ID_W    = 6,
  parameter int unsigned PRESS_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_rd_en,
  input  logic               cfg_wr_en,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               log_vld,
  input  logic [ID_W-1:0]    log_id,
  input  logic [PRESS_W-1:0] log_press,
  output logic               clr,
  output logic [DATA_W-1:0]  cfg_rdata
);
  localparam int unsigned FIELD_W = ID_W + PRESS_W;

  logic [DATA_W-1:0] detail_word;
  logic [DATA_W-1:0] rd_next;

  assign clr = cfg_wr_en && (cfg_addr == OFS_STATUS) && (cfg_wdata == CLEAR_WORD);

  always_comb begin
    detail_word = '0;
    detail_word[FIELD_W-1:0] = {log_press, log_id};
  end

  always_comb begin
    rd_next = '0;
    if (log_vld) begin
      if (cfg_addr == OFS_STATUS)      rd_next = STATUS_CODE;
      else if (cfg_addr == OFS_DETAIL) rd_next = detail_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            cfg_rdata <= '0;
    else if (cfg_rd_en) cfg_rdata <= rd_next;
  end
endmodule

// File: rtl/tgt_err_logger.sv
module tgt_err_logger #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SPAN_W  = 24,
  parameter int unsigned ID_W    = 6,
  parameter int unsigned PRESS_W = 2,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4500_0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [ID_W-1:0]            req_init_id,
  input  logic [PRESS_W-1:0]         req_press,
  output logic                       rsp_valid,
  output logic                       rsp_err,
  input  logic                       cfg_rd_en,
  input  logic                       cfg_wr_en,
  input  logic [tel_pkg::CFG_AW-1:0] cfg_addr,
  input  logic [tel_pkg::DATA_W-1:0] cfg_wdata,
  output logic [tel_pkg::DATA_W-1:0] cfg_rdata
);
  logic               err_evt;
  logic               clr;
  logic               log_vld;
  logic [ID_W-1:0]    log_id;
  logic [PRESS_W-1:0] log_press;

  tel_region_dec #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .REGION_BASE(REGION_BASE)) u_dec (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .err_evt(err_evt), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
  );

  tel_capture #(.ID_W(ID_W), .PRESS_W(PRESS_W)) u_cap (
    .clk(clk), .rst(rst), .err_evt(err_evt), .evt_id(req_init_id),
    .evt_press(req_press), .clr(clr), .log_vld(log_vld),
    .log_id(log_id), .log_press(log_press)
  );

  tel_regs #(.ID_W(ID_W), .PRESS_W(PRESS_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .log_vld(log_vld),
    .log_id(log_id), .log_press(log_press), .clr(clr), .cfg_rdata(cfg_rdata)
  );
endmodule

// File: rtl/tel_err_chk.sv
module tel_err_chk
  import tel_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SPAN_W  = 24,
  parameter int unsigned ID_W    = 6,
  parameter int unsigned PRESS_W = 2,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4500_0000
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic               cfg_rd_en,
  input logic               cfg_wr_en,
  input logic [CFG_AW-1:0]  cfg_addr,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic [DATA_W-1:0]  cfg_rdata,
  input logic               log_vld,
  input logic [ID_W-1:0]    log_id,
  input logic [PRESS_W-1:0] log_press
);
  logic hit_c;
  logic wipe_c;
  assign hit_c  = req_valid && (((req_addr ^ REGION_BASE) >> SPAN_W) == '0);
  assign wipe_c = cfg_wr_en && (cfg_addr == OFS_STATUS) && (cfg_wdata == CLEAR_WORD);

  // R1
  win_err_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    hit_c |=> (rsp_valid && rsp_err));

  // R2
  out_win_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_c |=> !rsp_valid);

  // R6
  log_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (log_vld && !wipe_c) |=> (log_vld && $stable(log_id) && $stable(log_press)));

  // R8
  log_wiped_chk: assert property (@(posedge clk) disable iff (rst)
    (wipe_c && !hit_c) |=> !log_vld);

  // R10
  wipe_and_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (wipe_c && hit_c) |=> log_vld);

  // R4
  status_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_en && log_vld && cfg_addr == OFS_STATUS) |=> (cfg_rdata == STATUS_CODE));

  // R3
  empty_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_en && !log_vld) |=> (cfg_rdata == '0));
endmodule

bind tgt_err_logger tel_err_chk #(
  .ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .ID_W(ID_W), .PRESS_W(PRESS_W), .REGION_BASE(REGION_BASE)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .cfg_rd_en(cfg_rd_en),
  .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .log_vld(log_vld), .log_id(log_id), .log_press(log_press)
);

// File: tb/test_tgt_err_logger.sv
`timescale 1ns/1ps
module test_tgt_err_logger;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [5:0]  req_init_id = '0;
  logic [1:0]  req_press = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic        cfg_rd_en = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tgt_err_logger i_tgt_err_logger (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_init_id(req_init_id), .req_press(req_press), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [5:0] id, input logic [1:0] pr,
                      input logic exp_rsp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_init_id = id; req_press = pr;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {30'b0, rsp_valid, rsp_err}, exp_rsp ? 32'h3 : 32'h0);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    check(req, cfg_rdata, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R3 reset rsp", {31'b0, rsp_valid}, 32'h0);
    check("R3 reset rdata", cfg_rdata, 32'h0);
    rd(12'h048, 32'h0, "R3 status empty");
    rd(12'h04C, 32'h0, "R3 detail empty");
  endtask

  task automatic t_outside();
    send(32'h4400_0600, 6'h01, 2'd3, 1'b0, "R2 below window");
    send(32'h44FF_FFFF, 6'h01, 2'd3, 1'b0, "R2 just below");
    send(32'h4600_0000, 6'h01, 2'd3, 1'b0, "R2 just above");
    rd(12'h048, 32'h0, "R2 not logged");
  endtask

  task automatic t_first();
    send(32'h4512_3450, 6'h0A, 2'd3, 1'b1, "R1 in window");
    rd(12'h048, 32'h0008_0001, "R4 status code");
    rd(12'h04C, 32'h0000_00CA, "R5 detail id/press");
  endtask

  task automatic t_sticky();
    send(32'h45FF_FFFC, 6'h08, 2'd1, 1'b1, "R7 answered while full");
    send(32'h4500_0000, 6'h3F, 2'd0, 1'b1, "R7 base edge");
    rd(12'h04C, 32'h0000_00CA, "R6 detail frozen");
    rd(12'h048, 32'h0008_0001, "R6 status held");
  endtask

  task automatic t_bad_clear();
    wr(12'h048, 32'hFFFF_FFFE);
    wr(12'h048, 32'h0000_0000);
    wr(12'h04C, 32'hFFFF_FFFF);
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h048, 32'h0008_0001, "R9 status kept");
    rd(12'h04C, 32'h0000_00CA, "R9 detail kept");
  endtask

  task automatic t_clear();
    wr(12'h048, 32'hFFFF_FFFF);
    rd(12'h048, 32'h0, "R8 status cleared");
    rd(12'h04C, 32'h0, "R8 detail cleared");
    send(32'h4500_0000, 6'h15, 2'd0, 1'b1, "R1 low edge");
    rd(12'h04C, 32'h0000_0015, "R8 recaptured proxy id R5");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h4580_0000; req_init_id = 6'h3F; req_press = 2'd2;
    cfg_wr_en = 1'b1; cfg_addr = 12'h048; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0; cfg_wr_en = 1'b0;
    check("R10 rsp", {30'b0, rsp_valid, rsp_err}, 32'h3);
    rd(12'h04C, 32'h0000_00BF, "R10 new error kept");
    rd(12'h048, 32'h0008_0001, "R10 status set");
  endtask

  task automatic t_other();
    rd(12'h040, 32'h0, "R11 unmapped offset");
    rd(12'h04D, 32'h0, "R11 misaligned offset");
    @(negedge clk);
    cfg_addr = 12'h048;
    @(negedge clk);
    check("R11 no strobe holds", cfg_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_outside();
    t_first();
    t_sticky();
    t_bad_clear();
    t_clear();
    t_same_cycle();
    t_other();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule